// File: doc/BRIEF.md
# Three-Wire Serial ADC Reader

This block is the host-side controller for a 16-bit converter that is read over three wires: an active-low chip-select, a serial clock and a serial data line. A single-cycle read request lowers chip-select. That falling edge both starts the conversion in the converter and opens the data transfer. The block then runs the serial clock from a programmable divider. It skips the preamble of falling edges during which the converter has no data on the line, then shifts in 16 bits with the most significant bit first. When the last bit is in, it returns the serial clock to its high idle level and raises chip-select. The sample is then presented as a signed two's complement word together with a one-cycle valid strobe.

Three parameters set the serial clock half-period in system clocks, the length of the preamble and the serial clock edge used for capture. Each data bit stays on the line from one serial falling edge to the next. Capture on the falling edge samples the bit that was set up a full period earlier, just before the converter replaces it, and so gives the fastest read rate. Capture on the rising edge samples in the middle of the bit. A busy output covers the whole transfer and the quiet gap after it, and requests made during that time are ignored.

Top module: `adc3w_reader`

## Requirements
- R1: After a synchronous reset, cs_n_o and sclk_o are 1, busy_o and valid_o are 0 and data_o is 0.
- R2: A request while the block is idle drives cs_n_o low and busy_o high at the next clock edge.
- R3: While cs_n_o is low, sclk_o changes level only every HALF_DIV system clocks, measured from the fall of cs_n_o. Its first change is a fall.
- R4: sclk_o is 1 in every cycle where cs_n_o is 1.
- R5: Serial fall n (counted from 1 within a transfer) makes the converter place the word's bit 21-n on the line, for n from 6 to 21. This puts the most significant bit first after a preamble of PRE_CYC = 5 falls. data_o receives exactly that 16-bit word.
- R6: In falling-edge capture mode a transfer has PRE_CYC+DATA_W+1 = 22 serial falls. In rising-edge capture mode it has PRE_CYC+DATA_W = 21 serial falls.
- R7: valid_o is high for exactly one clock, in the same cycle that data_o first shows the new sample. data_o then holds until the next sample.
- R8: data_o is signed two's complement: the word 0x8000 reads as -32768, 0xFFFF as -1 and 0x7FFF as +32767.
- R9: A request made while busy_o is high has no effect: the transfer in progress finishes unchanged, and no further transfer follows unless a new request arrives while idle.
- R10: Once cs_n_o rises it stays high for at least 2*HALF_DIV system clocks before it can fall again, even with the request held high.
- R11: When cs_n_o rises, sclk_o is already 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Read request, acted on only while idle |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip-select / conversion start |
| sclk_o | output | 1 | Serial clock, idles high |
| busy_o | output | 1 | Transfer or post-transfer gap in progress |
| valid_o | output | 1 | One-cycle strobe when data_o is updated |
| data_o | output | DATA_W | Last sample, signed two's complement |

## Verification
Two situations are hard to reach: a request arriving in the middle of a transfer, and a request held high across the end of one. The first is made by pulsing the request at several points inside a transfer. The bench then checks that the serial fall count and the received word are unchanged and that the block stays idle afterwards. The second holds the request high through two transfers back to back and measures how many cycles chip-select stays high between them. Both capture modes are covered by two instances with different divider settings, each fed by a converter model that counts serial falls.

// File: rtl/adc3w_pkg.sv
// Shared types for the three-wire ADC reader.
package adc3w_pkg;
    // Controller phases: idle, shifting, waiting for sclk high, quiet gap.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_TAIL = 2'd2,
        ST_GAP  = 2'd3
    } rd_state_e;
endpackage

// File: rtl/adc3w_sclk_gen.sv
// Serial clock generator.
// Toggles sclk_o every HALF_DIV system clocks while run_i is high and holds
// it high otherwise. fall_o and rise_o mark the system clock edge at which
// sclk_o changes. Assumes run_i is only dropped while sclk_o is high.
module adc3w_sclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic fall_o,
    output logic rise_o
);
    localparam int CW = $clog2(HALF_DIV) + 1;
    localparam logic [CW-1:0] TERM = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          tick;

    assign tick   = run_i && (cnt_q == TERM);
    assign fall_o = tick && sclk_o;
    assign rise_o = tick && !sclk_o;

    // Divider counter and serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q  <= '0;
            sclk_o <= 1'b1;
        end else if (cnt_q == TERM) begin
            cnt_q  <= '0;
            sclk_o <= ~sclk_o;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R3: the level moves only on a divider terminal count.
    a_r3_toggle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cnt_q != TERM) |=> $stable(sclk_o));
    // R4: generator parked means clock high.
    a_r4_parked_high: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> sclk_o);
endmodule

// File: rtl/adc3w_capture.sv
// Serial capture path.
// Counts serial falls since the transfer opened and skips the preamble.
// Shifts in DATA_W bits, MSB first, on the chosen edge. done_o stays high
// once the word is full, until clear_i. Assumes the converter updates the
// line just after each serial fall.
module adc3w_capture #(
    parameter int DATA_W       = 16,
    parameter int PRE_CYC      = 5,
    parameter bit CAPTURE_FALL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              fall_i,
    input  logic              rise_i,
    input  logic              sdata_i,
    output logic [DATA_W-1:0] word_o,
    output logic              done_o
);
    localparam int NFW = $clog2(PRE_CYC + DATA_W + 3) + 1;
    localparam int BW  = $clog2(DATA_W + 1);
    localparam logic [NFW-1:0] FIRST_DATA = NFW'(PRE_CYC + 1);
    localparam logic [BW-1:0]  FULL       = BW'(DATA_W);

    logic [NFW-1:0]    nfall_q;
    logic [BW-1:0]     nbit_q;
    logic [DATA_W-1:0] shreg_q;
    logic              cap;

    // Capture strobe picks the edge: the next fall, or the rise mid-bit.
    generate
        if (CAPTURE_FALL) begin : g_fall
            assign cap = fall_i && (nfall_q >= FIRST_DATA) && (nbit_q < FULL);
        end else begin : g_rise
            assign cap = rise_i && (nfall_q >= FIRST_DATA) && (nbit_q < FULL);
        end
    endgenerate

    // Serial fall counter for the open transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            nfall_q <= '0;
        end else if (fall_i) begin
            nfall_q <= nfall_q + 1'b1;
        end
    end

    // Shift register and bit count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            nbit_q  <= '0;
            shreg_q <= '0;
        end else if (cap) begin
            nbit_q  <= nbit_q + 1'b1;
            shreg_q <= {shreg_q[DATA_W-2:0], sdata_i};
        end
    end

    assign word_o = shreg_q;
    assign done_o = (nbit_q == FULL);

    // R5: never more than DATA_W bits taken.
    a_r5_bit_limit: assert property (@(posedge clk) disable iff (!rst_n)
        nbit_q <= FULL);
    // R5: no bit is taken while the preamble is running.
    a_r5_no_early_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (nfall_q < FIRST_DATA) |=> $stable(nbit_q) || nbit_q == '0);
endmodule

// File: rtl/adc3w_ctrl.sv
// Transfer sequencer.
// Opens a transfer on a request while idle and runs the serial clock until
// the capture path is full. It then lets the clock return high, closes
// chip-select and asks for the sample load. A quiet gap of 2*HALF_DIV clocks
// follows. Requests outside idle are ignored.
module adc3w_ctrl
    import adc3w_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic sclk_i,
    input  logic done_i,
    output logic cs_n_o,
    output logic busy_o,
    output logic run_o,
    output logic clear_o,
    output logic load_o
);
    localparam int GAP_LEN = 2 * HALF_DIV;
    localparam int GW      = $clog2(GAP_LEN + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_LEN - 1);

    rd_state_e     state_q;
    logic [GW-1:0] gap_q;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_i)          state_q <= ST_XFER;
                ST_XFER: if (done_i)         state_q <= ST_TAIL;
                ST_TAIL: if (sclk_i)         state_q <= ST_GAP;
                ST_GAP:  if (gap_q == GAP_LAST) state_q <= ST_IDLE;
                default:                     state_q <= ST_IDLE;
            endcase
        end
    end

    // Gap timer, counting only in the quiet phase.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_GAP) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assign cs_n_o  = (state_q == ST_IDLE) || (state_q == ST_GAP);
    assign busy_o  = (state_q != ST_IDLE);
    assign run_o   = (state_q == ST_XFER) || (state_q == ST_TAIL && !sclk_i);
    assign clear_o = (state_q == ST_IDLE);
    assign load_o  = (state_q == ST_TAIL) && sclk_i;

    // R2: idle request opens the transfer.
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_i) |=> (!cs_n_o && busy_o));
    // R9: chip-select low implies busy.
    a_r9_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);
    // R10: the gap cannot be cut short.
    a_r10_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && gap_q != GAP_LAST) |=> cs_n_o);
endmodule

// File: rtl/adc3w_reader.sv
// Three-wire serial ADC reader, top level.
// Ties the sequencer, serial clock generator and capture path together and
// holds the signed output sample. Assumes the converter drives sdata_i low
// after the preamble, then MSB first, updating just after each serial fall.
module adc3w_reader #(
    parameter int DATA_W       = 16,
    parameter int PRE_CYC      = 5,
    parameter int HALF_DIV     = 2,
    parameter bit CAPTURE_FALL = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_i,
    input  logic                     sdata_i,
    output logic                     cs_n_o,
    output logic                     sclk_o,
    output logic                     busy_o,
    output logic                     valid_o,
    output logic signed [DATA_W-1:0] data_o
);
    logic              run, clear, load, done, fall, rise;
    logic [DATA_W-1:0] word;

    adc3w_ctrl #(.HALF_DIV(HALF_DIV)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .sclk_i(sclk_o),
        .done_i(done), .cs_n_o(cs_n_o), .busy_o(busy_o), .run_o(run),
        .clear_o(clear), .load_o(load)
    );

    adc3w_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk(clk), .rst_n(rst_n), .run_i(run), .sclk_o(sclk_o),
        .fall_o(fall), .rise_o(rise)
    );

    adc3w_capture #(
        .DATA_W(DATA_W), .PRE_CYC(PRE_CYC), .CAPTURE_FALL(CAPTURE_FALL)
    ) u_cap (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .fall_i(fall),
        .rise_i(rise), .sdata_i(sdata_i), .word_o(word), .done_o(done)
    );

    // Output sample register and valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= load;
            if (load) data_o <= $signed(word);
        end
    end

    // R4: clock idles high outside a transfer.
    a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);
    // R7: strobe lasts one cycle.
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R7: sample only moves with the strobe.
    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o));
    // R11: chip-select rises only with the clock high.
    a_r11_close_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> sclk_o);
endmodule

// File: tb/tb_adc3w_reader.sv
// Behavioural converter: counts serial falls, drives the preamble low, then
// the word MSB first, one bit per fall.
module adc3w_conv_model (
    input  logic        cs_n,
    input  logic        sclk,
    input  logic [15:0] word,
    output logic        sd,
    output int          falls
);
    initial begin sd = 1'b1; falls = 0; end
    always @(negedge cs_n) begin falls = 0; sd = 1'b1; end
    always @(posedge cs_n) sd = 1'b1;
    always @(negedge sclk) begin
        if (!cs_n) begin
            falls = falls + 1;
            if (falls == 5) sd = 1'b0;
            else if (falls >= 6 && falls <= 21) sd = word[21 - falls];
        end
    end
endmodule

// Protocol monitor: sclk period while selected, idle level, level at close.
module adc3w_mon #(parameter int HALF = 2) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    output int   bad_per,
    output int   bad_idle,
    output int   bad_end
);
    logic p_cs = 1'b1, p_sclk = 1'b1;
    int   run_cnt = 0;
    initial begin bad_per = 0; bad_idle = 0; bad_end = 0; end
    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n && !sclk) bad_idle++;
            if (cs_n && !p_cs && !sclk) bad_end++;
            if (!cs_n && sclk != p_sclk) begin
                if (run_cnt != HALF) bad_per++;
                run_cnt = 1;
            end else if (!cs_n && p_cs) begin
                if (!sclk) bad_per++;
                run_cnt = 1;
            end else begin
                run_cnt++;
            end
        end
        p_cs = cs_n;
        p_sclk = sclk;
    end
endmodule

module tb_adc3w_reader;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, req_f = 1'b0, req_r = 1'b0;
    logic [15:0] wf = 16'h0, wr = 16'h0;
    logic sd_f, sd_r, cs_f, cs_r, sclk_f, sclk_r, busy_f, busy_r, val_f, val_r;
    logic signed [15:0] dat_f, dat_r;
    int falls_f, falls_r;
    int pf, idf, ef, pr, idr, er;
    int checks = 0, fails = 0;
    int cyc = 0;
    bit done_flag = 0;

    adc3w_reader #(.DATA_W(16), .PRE_CYC(5), .HALF_DIV(2), .CAPTURE_FALL(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_f), .sdata_i(sd_f), .cs_n_o(cs_f),
        .sclk_o(sclk_f), .busy_o(busy_f), .valid_o(val_f), .data_o(dat_f));
    adc3w_reader #(.DATA_W(16), .PRE_CYC(5), .HALF_DIV(3), .CAPTURE_FALL(1'b0)) dut_r (
        .clk(clk), .rst_n(rst_n), .req_i(req_r), .sdata_i(sd_r), .cs_n_o(cs_r),
        .sclk_o(sclk_r), .busy_o(busy_r), .valid_o(val_r), .data_o(dat_r));

    adc3w_conv_model m_f (.cs_n(cs_f), .sclk(sclk_f), .word(wf), .sd(sd_f), .falls(falls_f));
    adc3w_conv_model m_r (.cs_n(cs_r), .sclk(sclk_r), .word(wr), .sd(sd_r), .falls(falls_r));
    adc3w_mon #(.HALF(2)) mon_f (.clk(clk), .rst_n(rst_n), .cs_n(cs_f), .sclk(sclk_f),
        .bad_per(pf), .bad_idle(idf), .bad_end(ef));
    adc3w_mon #(.HALF(3)) mon_r (.clk(clk), .rst_n(rst_n), .cs_n(cs_r), .sclk(sclk_r),
        .bad_per(pr), .bad_idle(idr), .bad_end(er));

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            finish_run();
        end
    end

    task automatic wait_valid(input bit use_r, output bit seen);
        seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            seen = use_r ? val_r : val_f;
        end
    endtask

    // One read: start check, word, fall count, strobe, protocol monitors.
    task automatic t_read(input bit use_r, input logic [15:0] w);
        bit seen;
        int exp_falls = use_r ? 21 : 22;
        if (use_r) begin wr = w; req_r = 1'b1; end else begin wf = w; req_f = 1'b1; end
        @(negedge clk);
        req_f = 1'b0; req_r = 1'b0;
        chk(use_r ? (!cs_r && busy_r) : (!cs_f && busy_f), "R2", "start", 0, 1);
        wait_valid(use_r, seen);
        chk(seen, "R7", "valid seen", seen, 1);
        chk((use_r ? dat_r : dat_f) == $signed(w), "R5", "word",
            use_r ? dat_r : dat_f, $signed(w));
        chk((use_r ? falls_r : falls_f) == exp_falls, "R6", "fall count",
            use_r ? falls_r : falls_f, exp_falls);
        chk(use_r ? cs_r : cs_f, "R11", "cs high at load", 0, 1);
        @(negedge clk);
        chk(!(use_r ? val_r : val_f), "R7", "strobe width", 1, 0);
        chk((use_r ? dat_r : dat_f) == $signed(w), "R7", "data held",
            use_r ? dat_r : dat_f, $signed(w));
        chk((use_r ? pr : pf) == 0, "R3", "sclk half period", use_r ? pr : pf, 0);
        chk((use_r ? idr : idf) == 0, "R4", "sclk idle", use_r ? idr : idf, 0);
        chk((use_r ? er : ef) == 0, "R11", "sclk at close", use_r ? er : ef, 0);
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(cs_f && cs_r, "R1", "cs_n", cs_f, 1);
        chk(sclk_f && sclk_r, "R1", "sclk", sclk_f, 1);
        chk(!busy_f && !busy_r, "R1", "busy", busy_f, 0);
        chk(!val_f && !val_r, "R1", "valid", val_f, 0);
        chk(dat_f == 0 && dat_r == 0, "R1", "data", dat_f, 0);
    endtask

    task automatic t_signed();
        t_read(0, 16'h8000);
        chk(dat_f == -32768, "R8", "most negative", dat_f, -32768);
        t_read(0, 16'hFFFF);
        chk(dat_f == -1, "R8", "minus one", dat_f, -1);
        t_read(1, 16'h7FFF);
        chk(dat_r == 32767, "R8", "most positive", dat_r, 32767);
    endtask

    // Requests during a transfer must not disturb it or queue another.
    task automatic t_busy_ignore();
        bit seen;
        wf = 16'h3C5A; req_f = 1'b1;
        @(negedge clk); req_f = 1'b0;
        repeat (10) @(negedge clk);
        chk(busy_f, "R9", "busy mid transfer", busy_f, 1);
        req_f = 1'b1; @(negedge clk); req_f = 1'b0;
        repeat (30) @(negedge clk);
        req_f = 1'b1; @(negedge clk); req_f = 1'b0;
        wait_valid(0, seen);
        chk(seen && dat_f == 16'sh3C5A, "R9", "word after extra requests", dat_f, 16'sh3C5A);
        chk(falls_f == 22, "R9", "falls after extra requests", falls_f, 22);
        repeat (15) @(negedge clk);
        chk(!busy_f && cs_f, "R9", "no queued transfer", busy_f, 0);
    endtask

    // Held request: measure the chip-select high gap between transfers.
    task automatic t_gap();
        bit seen;
        int hi = 0;
        wf = 16'h1234; req_f = 1'b1;
        wait_valid(0, seen);
        chk(seen && dat_f == 16'sh1234, "R10", "first of pair", dat_f, 16'sh1234);
        hi = 1;
        for (int i = 0; i < 50 && cs_f; i++) begin @(negedge clk); if (cs_f) hi++; end
        wf = 16'hBEEF;
        chk(hi >= 4, "R10", "cs high cycles", hi, 4);
        req_f = 1'b0;
        wait_valid(0, seen);
        chk(seen && dat_f == $signed(16'hBEEF), "R10", "second of pair", dat_f, $signed(16'hBEEF));
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_read(0, 16'h0000);
        t_read(0, 16'h0001);
        t_read(0, 16'hA5C3);
        t_read(1, 16'h5A3C);
        t_read(1, 16'h8001);
        t_signed();
        t_busy_ignore();
        t_gap();
        finish_run();
    end
endmodule